// File: doc/BRIEF.md
# Configurable Serial Audio Input Receiver

This block takes a two-channel serial audio stream and turns it into parallel samples. The stream has three wires: a bit clock, a frame clock whose level tells the two channels apart, and a serial data line. All three are asynchronous to the system clock. They pass through a two-stage synchronizer. Rising edges of the bit clock are then found in the system clock domain, and the frame clock and data are taken on each such edge.

Three static control inputs set the framing:

- a word-length code selects 16, 20 or 24-bit words;
- a format bit selects right-justified or I2S framing;
- a polarity bit selects which frame-clock level carries the left channel.

Each finished word is sign-extended to 24 bits and placed on the left or right output. A one-cycle strobe marks the cycle in which a right-channel word, and with it a complete frame, appears. The control inputs are meant to be changed only while the block is held in reset or the bit clock is idle.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_n` is low, `left_o`, `right_o` and `frame_valid_o` are all zero.
- R2: Each input crosses two synchronizing flops. An output update caused by a bit-clock rise appears at the third system clock edge that samples the bit clock high. Frame clock and data are taken with the same delay as the bit clock.
- R3: After reset, the first bit-clock rise only records the frame-clock level. The first frame-clock change seen on a later rise only starts word tracking and updates no output. Every later change commits the word of the half-frame that just ended.
- R4: With `cfg_left_hi` = 0 a low frame clock marks the left channel; with `cfg_left_hi` = 1 a high frame clock marks it. A committed word goes to the channel of the frame-clock level of the half-frame that ended.
- R5: `cfg_len` selects the word length N: 2'b00 gives 16 bits, 2'b01 gives 20 bits, 2'b10 gives 24 bits, and the reserved code 2'b11 also gives 24 bits.
- R6: With `cfg_i2s` = 0 (right-justified), the word is the last N data bits taken before the frame-clock change, MSB first. The half-frame is assumed to hold at least N bits.
- R7: With `cfg_i2s` = 1 (I2S), the bit taken on the rise that first sees the new frame-clock level is not part of the new word. The MSB is taken on the next rise, followed by the remaining N-1 bits, MSB first. Bits not received before the next change read as 0.
- R8: A word shorter than 24 bits is sign-extended from its bit N-1 to 24 bits.
- R9: A right-channel commit updates `right_o` and raises `frame_valid_o` for exactly one cycle. A left-channel commit updates `left_o` with `frame_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Serial bit clock, asynchronous |
| frame_clk | input | 1 | Channel-select frame clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| cfg_len | input | 2 | Word-length code (R5) |
| cfg_i2s | input | 1 | 0 right-justified, 1 I2S |
| cfg_left_hi | input | 1 | Frame-clock level that marks the left channel |
| left_o | output | 24 | Sign-extended left sample |
| right_o | output | 24 | Sign-extended right sample |
| frame_valid_o | output | 1 | One-cycle pulse with each new right sample |

## Verification
Committing a finished word and capturing the first bit of the next half-frame happen on the same bit-clock rise. In right-justified mode that bit belongs to the new word; in I2S mode it is discarded. Every frame-clock change provokes this case. The filler bits around each word are set opposite to what a correct capture would use, so a bit that lands in the wrong word shows up as a wrong value. A behavioural model checks the outputs every system clock, and directed checks of the final samples and the strobe count follow each stream.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SAMPLE_W = 24,
  parameter int POS_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_clk,
  input  logic                frame_clk,
  input  logic                ser_data,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_i2s,
  input  logic                cfg_left_hi,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                frame_valid_o
);
  localparam int IDX_W = $clog2(SAMPLE_W + 1);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [2:0] bck_p;
  logic [1:0] fck_p, dat_p;
  logic       started, armed, fck_last;
  logic [POS_W-1:0]    pos;
  logic [SAMPLE_W-1:0] shreg, acc, raw, ext;
  logic [IDX_W-1:0]    wlen;
  logic                sgn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_p <= '0;
      fck_p <= '0;
      dat_p <= '0;
    end else begin
      bck_p <= {bck_p[1:0], bit_clk};
      fck_p <= {fck_p[0], frame_clk};
      dat_p <= {dat_p[0], ser_data};
    end
  end

  wire rise = bck_p[1] & ~bck_p[2];
  wire fck  = fck_p[1];
  wire din  = dat_p[1];
  wire chg  = rise & started & (fck != fck_last);
  wire [POS_W-1:0] pos_nx = (pos == POS_MAX) ? pos : pos + 1'b1;
  wire wr_en = (int'(pos_nx) >= 1) && (int'(pos_nx) <= int'(wlen));
  int  wr_idx;
  assign wr_idx = int'(wlen) - int'(pos_nx);

  always_comb begin
    case (cfg_len)
      2'b00:   wlen = IDX_W'(SAMPLE_W - 8);
      2'b01:   wlen = IDX_W'(SAMPLE_W - 4);
      default: wlen = IDX_W'(SAMPLE_W);
    endcase
  end

  assign raw = cfg_i2s ? acc : shreg;

  always_comb begin
    sgn = 1'b0;
    for (int i = 0; i < SAMPLE_W; i++)
      if (i == int'(wlen) - 1) sgn = raw[i];
    for (int i = 0; i < SAMPLE_W; i++)
      ext[i] = (i < int'(wlen)) ? raw[i] : sgn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started       <= 1'b0;
      armed         <= 1'b0;
      fck_last      <= 1'b0;
      pos           <= '0;
      shreg         <= '0;
      acc           <= '0;
      left_o        <= '0;
      right_o       <= '0;
      frame_valid_o <= 1'b0;
    end else begin
      frame_valid_o <= 1'b0;
      if (rise) begin
        shreg <= {shreg[SAMPLE_W-2:0], din};
        if (!started) begin
          started  <= 1'b1;
          fck_last <= fck;
        end
        if (chg) begin
          fck_last <= fck;
          armed    <= 1'b1;
          pos      <= '0;
          acc      <= '0;
          if (armed) begin
            if (fck_last == cfg_left_hi) begin
              left_o <= ext;
            end else begin
              right_o       <= ext;
              frame_valid_o <= 1'b1;
            end
          end
        end else begin
          pos <= pos_nx;
          for (int i = 0; i < SAMPLE_W; i++)
            if (wr_en && i == wr_idx) acc[i] <= din;
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          cfg_len,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                frame_valid_o
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o |=> !frame_valid_o);

  a_r9_right_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right_o) |-> frame_valid_o);

  a_r9_left_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(left_o) |-> !frame_valid_o);

  a_r8_sext_short_word: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid_o && $past(cfg_len) == 2'b00) |->
      (right_o[SAMPLE_W-1:SAMPLE_W-9] == {9{right_o[SAMPLE_W-9]}}));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len),
  .left_o(left_o), .right_o(right_o), .frame_valid_o(frame_valid_o)
);

// File: tb/sim_serial_audio_rx.sv
`timescale 1ns/1ps
module sim_serial_audio_rx;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, bit_clk = 1'b0, frame_clk = 1'b0, ser_data = 1'b0;
  logic [1:0] cfg_len = 2'b00;
  logic cfg_i2s = 1'b0, cfg_left_hi = 1'b0;
  logic [23:0] left_o, right_o;
  logic frame_valid_o;

  serial_audio_rx u0 (.clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_clk(frame_clk),
    .ser_data(ser_data), .cfg_len(cfg_len), .cfg_i2s(cfg_i2s), .cfg_left_hi(cfg_left_hi),
    .left_o(left_o), .right_o(right_o), .frame_valid_o(frame_valid_o));

  int total = 0, bad = 0, vcount = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int len_of(logic [1:0] c);
    return (c == 2'b00) ? 16 : (c == 2'b01) ? 20 : 24;
  endfunction

  function automatic logic [23:0] sx(logic [23:0] v, int n);
    logic [23:0] r = v;
    for (int i = n; i < 24; i++) r[i] = v[n-1];
    return r;
  endfunction

  // behavioural reference model
  bit p1c, p2c, p3c, p1w, p2w, p1d, p2d;
  bit m_started, m_armed, m_last, e_v;
  bit q[$];
  logic [23:0] e_l, e_r;

  function automatic logic [23:0] word_of(bit qq[$], int n, bit i2s);
    logic [23:0] raw = '0;
    int sz = qq.size();
    for (int k = 0; k < n; k++) begin
      int idx = i2s ? k + 1 : sz - n + k;
      raw = {raw[22:0], (idx >= 0 && idx < sz) ? qq[idx] : 1'b0};
    end
    return sx(raw, n);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {p1c, p2c, p3c, p1w, p2w, p1d, p2d} = '0;
      m_started = 0; m_armed = 0; m_last = 0; e_v = 0;
      q.delete(); e_l = '0; e_r = '0;
    end else begin
      e_v = 0;
      if (p2c && !p3c) begin
        if (!m_started) begin
          m_started = 1; m_last = p2w; q.delete(); q.push_back(p2d);
        end else if (p2w != m_last) begin
          if (m_armed) begin
            if (m_last == cfg_left_hi) e_l = word_of(q, len_of(cfg_len), cfg_i2s);
            else begin e_r = word_of(q, len_of(cfg_len), cfg_i2s); e_v = 1; end
          end
          m_armed = 1; m_last = p2w; q.delete(); q.push_back(p2d);
        end else q.push_back(p2d);
      end
      p3c = p2c; p2c = p1c; p1c = bit_clk;
      p2w = p1w; p1w = frame_clk;
      p2d = p1d; p1d = ser_data;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check(left_o == e_l, "R2 R6/R7 left per-cycle", left_o, e_l);
      check(right_o == e_r, "R2 R6/R7 right per-cycle", right_o, e_r);
      check(frame_valid_o == e_v, "R9 strobe per-cycle", frame_valid_o, e_v);
      if (rst_n && frame_valid_o) vcount++;
    end
  end

  task automatic send_bit(bit w, bit d);
    @(negedge clk); bit_clk = 0; frame_clk = w; ser_data = d;
    repeat (2) @(negedge clk);
    bit_clk = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_half(bit w, logic [23:0] v, int n, int h, bit i2s);
    for (int p = 0; p < h; p++) begin
      bit d;
      if (i2s) d = (p >= 1 && p <= n) ? v[n-p] : ~v[n-1];
      else     d = (p >= h - n) ? v[n-1-(p-(h-n))] : ~v[n-1];
      send_bit(w, d);
    end
  endtask

  function automatic logic [23:0] pick(int f, int n, int salt);
    logic [23:0] v = 24'(f * 32'h5A3C1 + 32'h9E377 + salt * 32'h1111);
    for (int i = n; i < 24; i++) v[i] = 1'b0;
    v[n-1] = f[0];
    return v;
  endfunction

  task automatic run_stream(logic [1:0] code, bit i2s, bit lhi, int h, int nfr);
    int n = len_of(code);
    logic [23:0] lv, rv;
    @(negedge clk);
    rst_n = 0; cfg_len = code; cfg_i2s = i2s; cfg_left_hi = lhi;
    bit_clk = 0; frame_clk = ~lhi; ser_data = 1;
    repeat (4) @(negedge clk);
    check(left_o == 0 && right_o == 0 && frame_valid_o == 0, "R1 reset outputs",
          {left_o, right_o, frame_valid_o}, 0);
    rst_n = 1;
    vcount = 0;
    for (int i = 0; i < 3; i++) send_bit(~lhi, 1'b1);
    for (int f = 0; f < nfr; f++) begin
      lv = pick(f, n, 2 * int'(code) + int'(i2s));
      rv = pick(f + 1, n, 3 + int'(code));
      send_half(lhi, lv, n, h, i2s);
      if (f == 0)
        check(left_o == 0 && right_o == 0 && vcount == 0, "R3 first change commits nothing",
              {left_o, right_o}, 0);
      send_half(~lhi, rv, n, h, i2s);
    end
    for (int i = 0; i < 2; i++) send_bit(lhi, 1'b0);
    repeat (4) @(negedge clk);
    check(left_o == sx(lv, n), i2s ? "R4 R5 R7 R8 final left" : "R4 R5 R6 R8 final left",
          left_o, sx(lv, n));
    check(right_o == sx(rv, n), i2s ? "R4 R5 R7 R8 final right" : "R4 R5 R6 R8 final right",
          right_o, sx(rv, n));
    check(vcount == nfr, "R9 one strobe per frame", vcount, nfr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    run_stream(2'b00, 0, 0, 32, 3);
    run_stream(2'b01, 0, 1, 20, 2);
    run_stream(2'b10, 0, 0, 24, 2);
    run_stream(2'b00, 1, 0, 32, 3);
    run_stream(2'b11, 1, 1, 25, 2);
    run_stream(2'b01, 1, 1, 32, 2);
    run_stream(2'b11, 0, 1, 30, 2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule